// File: doc/BRIEF.md
# Fetch-Stage Branch Direction and Target Predictor

This block sits beside the fetch stage and answers, in the same cycle, two questions about the current fetch address. It asks whether a branch at this address is likely to be taken, and which address fetch should use next. Direction comes from a direct-mapped array of 2-bit saturating counters. The target comes from a direct-mapped target cache whose entries carry a valid bit, an address tag and the stored destination. When the counter predicts taken and the target cache holds a matching entry, the predicted next address is the stored target. In every other case it is the sequential address, fetch address plus four.

The resolve stage trains the block through an update port. This port carries the branch address, the real outcome, the real destination and a flag that says whether the earlier prediction was wrong. Training takes effect at the clock edge, so a lookup made in the same cycle as an update still sees the earlier contents. Both tables are indexed by the same low address bits above the word offset. Pipeline flushing is left to the surrounding fetch logic.

Top module: `branch_predictor`

## Requirements
- R1: After synchronous active-low reset every direction counter holds weak not-taken (01) and every target entry is invalid. Any lookup then gives pred_taken=0 and pred_next_pc=fetch_pc+4, and the addition wraps modulo 2^32.
- R2: Counters use the encoding 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. pred_taken is the counter's upper bit.
- R3: pred_next_pc equals the stored target only when pred_taken=1 and the indexed target entry is valid with a tag equal to fetch_pc[31:8]. Otherwise it equals fetch_pc+4.
- R4: An update with upd_taken=1 moves the indexed counter one step toward 11 and holds it at 11 when it is already there.
- R5: An update with upd_taken=0 moves the indexed counter one step toward 00 and holds it at 00 when it is already there.
- R6: From a strong state, a single opposite outcome leaves the predicted direction unchanged, and a second opposite outcome in a row flips it.
- R7: Both tables are indexed by pc[7:2]. Addresses that differ only above bit 7 share one counter and one target entry. A lookup whose tag differs from the stored tag is a miss.
- R8: A taken update writes the target entry (valid, tag, target) when the entry misses for that address or when upd_mispredict=1. A taken update that hits with upd_mispredict=0 leaves the stored target unchanged.
- R9: A not-taken update never changes the target cache.
- R10: A lookup in the same cycle as an update to the same entry returns the contents from before the update.
- R11: An update changes only the entry at its own index, and lookups change no state.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_taken | output | 1 | Predicted direction for fetch_pc |
| pred_next_pc | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented for training |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch |
| upd_target | input | 32 | Real destination of the resolved branch |
| upd_mispredict | input | 1 | The earlier prediction for this branch was wrong |

## Verification
The counter path is driven with runs of equal outcomes longer than the counter range, which shows saturation at both ends. It is also driven with alternating pairs of outcomes, which separate a hysteresis counter from a one-bit history. Target behaviour is tried with a first-time taken branch, a correctly predicted hit with a different target and the flag clear, and the same hit with the flag set. Together these tell apart "write on miss or mispredict" from "always write" and "never rewrite". Two addresses that differ only above bit 7 show that the counter is shared while the tag keeps the targets apart. A lookup and an update to the same entry in one cycle show that results come from the old contents.

// File: rtl/bp_pkg.sv
// Shared types and the saturating step rule for the branch predictor.
package bp_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_STRONG_NT = 2'b00;
    localparam ctr_t CTR_WEAK_NT   = 2'b01;
    localparam ctr_t CTR_WEAK_T    = 2'b10;
    localparam ctr_t CTR_STRONG_T  = 2'b11;

    // One saturating step toward taken or not-taken.
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_STRONG_T) nxt = cur + 2'd1;
        end else begin
            if (cur != CTR_STRONG_NT) nxt = cur - 2'd1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/bp_sat_counter.sv
// One 2-bit hysteresis counter.
// Assumes: upd_en is high for at most the cycles in which this entry is trained.
module bp_sat_counter
    import bp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic upd_en,
    input  logic taken,
    output ctr_t state
);

    // Hold the counter, reset it to weak not-taken, or step it on training.
    always_ff @(posedge clk) begin
        if (!rst_n)      state <= CTR_WEAK_NT;
        else if (upd_en) state <= ctr_step(state, taken);
    end

endmodule

// File: rtl/bp_dir_table.sv
// Direct-mapped direction table: one counter per index, with a combinational read.
// Assumes: there is one read port and one write port, and the read returns the pre-edge state.
module bp_dir_table
    import bp_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    localparam int DEPTH = 1 << IDX_W;

    ctr_t ctr_q [DEPTH];

    // One counter cell for each index; only the addressed cell is trained.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        bp_sat_counter u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .upd_en (wr_en && (wr_idx == IDX_W'(i))),
            .taken  (wr_taken),
            .state  (ctr_q[i])
        );
    end

    // The predicted direction is the upper bit of the addressed counter.
    always_comb rd_taken = ctr_q[rd_idx][1];

endmodule

// File: rtl/bp_target_buf.sv
// Direct-mapped target cache holding a valid bit, a tag and a target per entry.
// Assumes: the read is combinational, writes land at the clock edge, and only
// the valid bits are reset.
module bp_target_buf #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6,
    parameter int TAG_W = PC_W - IDX_W - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    output logic [PC_W-1:0]  rd_target,
    input  logic             wr_valid,
    input  logic             wr_taken,
    input  logic             wr_mispredict,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PC_W-1:0]  wr_target
);

    localparam int DEPTH = 1 << IDX_W;

    logic             vld_q [DEPTH];
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [PC_W-1:0]  tgt_q [DEPTH];
    logic             wr_hit;
    logic             wr_en;

    // Lookup: a hit needs a valid entry with a matching tag.
    always_comb begin
        rd_hit    = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
        rd_target = tgt_q[rd_idx];
    end

    // Write decision: taken branches that miss, or that were mispredicted.
    always_comb begin
        wr_hit = vld_q[wr_idx] && (tag_q[wr_idx] == wr_tag);
        wr_en  = wr_valid && wr_taken && (!wr_hit || wr_mispredict);
    end

    // Valid bits: cleared on reset, set when an entry is written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) vld_q[i] <= 1'b0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    // Tag and target storage, which needs no reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_target;
        end
    end

endmodule

// File: rtl/branch_predictor.sv
// Fetch-stage predictor: a direction table plus a target cache, looked up
// combinationally with the fetch address and trained from the resolve stage.
// Assumes: instructions are word aligned, so pc[1:0] is ignored.
module branch_predictor #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_taken,
    output logic [PC_W-1:0] pred_next_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target,
    input  logic            upd_mispredict
);

    localparam int TAG_W = PC_W - IDX_W - 2;
    localparam int IDX_LO = 2;
    localparam int IDX_HI = IDX_LO + IDX_W - 1;

    logic [IDX_W-1:0] f_idx, u_idx;
    logic [TAG_W-1:0] f_tag, u_tag;
    logic             dir_taken;
    logic             tgt_hit;
    logic [PC_W-1:0]  tgt_pc;
    logic             unused_align;

    // Split both addresses into an index and a tag.
    always_comb begin
        f_idx = fetch_pc[IDX_HI:IDX_LO];
        f_tag = fetch_pc[PC_W-1:IDX_HI+1];
        u_idx = upd_pc[IDX_HI:IDX_LO];
        u_tag = upd_pc[PC_W-1:IDX_HI+1];
    end

    assign unused_align = ^{fetch_pc[1:0], upd_pc[1:0]};

    bp_dir_table #(.IDX_W(IDX_W)) u_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (f_idx),
        .rd_taken (dir_taken),
        .wr_en    (upd_valid),
        .wr_idx   (u_idx),
        .wr_taken (upd_taken)
    );

    bp_target_buf #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tgt (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_idx        (f_idx),
        .rd_tag        (f_tag),
        .rd_hit        (tgt_hit),
        .rd_target     (tgt_pc),
        .wr_valid      (upd_valid),
        .wr_taken      (upd_taken),
        .wr_mispredict (upd_mispredict),
        .wr_idx        (u_idx),
        .wr_tag        (u_tag),
        .wr_target     (upd_target)
    );

    // Next-address select: redirect only on a taken prediction with a target hit.
    always_comb begin
        pred_taken   = dir_taken;
        pred_next_pc = (dir_taken && tgt_hit) ? tgt_pc : fetch_pc + PC_W'(4);
    end

endmodule

// File: rtl/bp_checker.sv
// Port-level properties of the branch predictor, bound to every instance.
module bp_checker #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] fetch_pc,
    input logic            pred_taken,
    input logic [PC_W-1:0] pred_next_pc,
    input logic            upd_valid,
    input logic [PC_W-1:0] upd_pc,
    input logic            upd_taken,
    input logic [PC_W-1:0] upd_target,
    input logic            upd_mispredict
);

    // R3: without a taken prediction fetch falls through
    p_fallthrough_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken |-> pred_next_pc == fetch_pc + PC_W'(4));

    // R4: a taken outcome on a taken prediction keeps it taken
    p_taken_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && upd_pc == fetch_pc && pred_taken)
        |=> (fetch_pc != $past(fetch_pc)) || pred_taken);

    // R5: a not-taken outcome on a not-taken prediction keeps it not-taken
    p_nt_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && upd_pc == fetch_pc && !pred_taken)
        |=> (fetch_pc != $past(fetch_pc)) || !pred_taken);

    // R8: a mispredicted taken update on a taken entry installs the new target
    p_mispredict_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && upd_mispredict && upd_pc == fetch_pc && pred_taken)
        |=> (fetch_pc != $past(fetch_pc)) || pred_next_pc == $past(upd_target));

    // R11: with no update, a repeated lookup gives the same answer
    p_no_update_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> (fetch_pc != $past(fetch_pc))
                       || ($stable(pred_taken) && $stable(pred_next_pc)));

endmodule

bind branch_predictor bp_checker #(.PC_W(PC_W)) u_bp_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetch_pc       (fetch_pc),
    .pred_taken     (pred_taken),
    .pred_next_pc   (pred_next_pc),
    .upd_valid      (upd_valid),
    .upd_pc         (upd_pc),
    .upd_taken      (upd_taken),
    .upd_target     (upd_target),
    .upd_mispredict (upd_mispredict)
);

// File: tb/branch_predictor_test.sv
// Scoreboard bench: the driver queues expected lookups and the monitor compares them.
module branch_predictor_test;

    localparam int CLK_P = 10;

    typedef struct {
        logic        taken;
        logic [31:0] next;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_taken;
    logic [31:0] pred_next_pc;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;
    logic        upd_mispredict = 1'b0;

    exp_t exp_q [$];
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    event probe;

    always #(CLK_P/2) clk = ~clk;

    branch_predictor uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .fetch_pc       (fetch_pc),
        .pred_taken     (pred_taken),
        .pred_next_pc   (pred_next_pc),
        .upd_valid      (upd_valid),
        .upd_pc         (upd_pc),
        .upd_taken      (upd_taken),
        .upd_target     (upd_target),
        .upd_mispredict (upd_mispredict)
    );

    // Monitor: pop one expected item per probe and compare it with the outputs.
    always @(probe) begin
        exp_t e;
        e = exp_q.pop_front();
        n_run++;
        if (pred_taken !== e.taken || pred_next_pc !== e.next) begin
            n_fail++;
            $display("FAIL %s: taken=%0d next=%h expected taken=%0d next=%h",
                     e.req, pred_taken, pred_next_pc, e.taken, e.next);
        end
    end

    // One cycle: drive the fetch address and an optional update; check if asked.
    task automatic cyc(input bit chk, input logic [31:0] fpc,
                       input bit uv, input logic [31:0] upc, input bit ut,
                       input logic [31:0] utgt, input bit um,
                       input logic et, input logic [31:0] en, input string req);
        exp_t e;
        @(negedge clk);
        fetch_pc       = fpc;
        upd_valid      = uv;
        upd_pc         = upc;
        upd_taken      = ut;
        upd_target     = utgt;
        upd_mispredict = um;
        if (chk) begin
            e.taken = et; e.next = en; e.req = req;
            exp_q.push_back(e);
            #(CLK_P/4);
            -> probe;
        end
    endtask

    task automatic look(input logic [31:0] pc, input logic et,
                        input logic [31:0] en, input string req);
        cyc(1'b1, pc, 1'b0, '0, 1'b0, '0, 1'b0, et, en, req);
    endtask

    task automatic train(input logic [31:0] pc, input bit t,
                         input logic [31:0] tgt, input bit m);
        cyc(1'b0, 32'h0, 1'b1, pc, t, tgt, m, 1'b0, '0, "");
    endtask

    localparam logic [31:0] PA = 32'h0000_1004;
    localparam logic [31:0] PB = 32'h0000_3008;
    localparam logic [31:0] PC = 32'h0000_1104;
    localparam logic [31:0] PD = 32'h0000_400C;
    localparam logic [31:0] T1 = 32'h0000_2000;
    localparam logic [31:0] T2 = 32'h0000_2400;
    localparam logic [31:0] T3 = 32'h0000_5000;
    localparam logic [31:0] T4 = 32'h0000_6000;
    localparam logic [31:0] TB = 32'h0000_7000;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, including the wrap of the sequential address
        look(PA, 1'b0, PA + 4, "R1 reset lookup");
        look(32'hFFFF_FFFC, 1'b0, 32'h0, "R1 wrap");
        // R2/R3/R4: first taken update 01->10, target installed on the miss
        train(PA, 1'b1, T1, 1'b1);
        look(PA, 1'b1, T1, "R2 R3 R4 weak taken redirects");
        // R6: 10->11, then one not-taken gives 10 and stays taken
        train(PA, 1'b1, T1, 1'b0);
        train(PA, 1'b0, 32'h0, 1'b1);
        look(PA, 1'b1, T1, "R6 one opposite outcome keeps direction");
        train(PA, 1'b0, 32'h0, 1'b1);
        look(PA, 1'b0, PA + 4, "R6 second opposite outcome flips");
        // R8/R9: 01->10; a hit with the flag clear keeps T1, and not-taken kept the entry
        train(PA, 1'b1, T2, 1'b0);
        look(PA, 1'b1, T1, "R8 R9 hit without mispredict keeps target");
        // R8: a mispredict rewrites the target (10->11)
        train(PA, 1'b1, T2, 1'b1);
        look(PA, 1'b1, T2, "R8 mispredict rewrites target");
        // R4: saturation at 11, then one not-taken gives 10
        for (int i = 0; i < 3; i++) train(PA, 1'b1, T2, 1'b0);
        train(PA, 1'b0, 32'h0, 1'b1);
        look(PA, 1'b1, T2, "R4 saturated at strong taken");
        // R5: saturation at 00, then one taken gives 01
        for (int i = 0; i < 3; i++) train(PB, 1'b0, 32'h0, 1'b0);
        train(PB, 1'b1, TB, 1'b1);
        look(PB, 1'b0, PB + 4, "R5 saturated at strong not-taken");
        train(PB, 1'b1, TB, 1'b1);
        look(PB, 1'b1, TB, "R5 R4 recovers to weak taken");
        // R7: alias C shares A's counter (10) but misses on the tag
        look(PC, 1'b1, PC + 4, "R7 tag mismatch falls through");
        train(PC, 1'b1, T3, 1'b0);
        look(PC, 1'b1, T3, "R7 alias installs its own tag");
        look(PA, 1'b1, PA + 4, "R7 alias replaced A's entry");
        // R10: lookup and update in one cycle see the old contents
        cyc(1'b1, PD, 1'b1, PD, 1'b1, T4, 1'b1, 1'b0, PD + 4, "R10 same-cycle old contents");
        look(PD, 1'b1, T4, "R10 update visible next cycle");
        // R11: no spill onto other entries, and lookups are stable
        look(PB, 1'b1, TB, "R11 other entry unchanged");
        look(PD, 1'b1, T4, "R11 repeated lookup stable");
        look(PD, 1'b1, T4, "R11 repeated lookup stable again");
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule